// File: doc/BRIEF.md
# Micromirror Supply Sequencing Controller

This block is a synchronous state machine that brings up and tears down the supplies of a micromirror display device. It works together with the display controller that parks the mirrors. At power-up it enables the two logic supplies first. Once both report good, it releases the controller reset and the output-enable that gates LVCMOS-driven signals. It then enables the offset and reset high-voltage rails, and turns on the bias rail a fixed number of cycles later.

A software power-down request or a detected loss of input power starts the shutdown. The block raises a park request and freezes every rail for a timed hold, so the display controller can flatten the mirrors. It then removes bias and reset, and a fixed gap later removes offset. The logic supplies stay enabled until the environment reports that the high-voltage rails are discharged close to ground.

After a power loss, the machine ends fully off. After a software request, it keeps the logic rails on and pulses the controller reset low for a timed interval, then powers the high-voltage rails again. All durations are given in time units and turned into cycle counts from a clock-frequency parameter.

Top module: `mmd_rail_seq`

## Requirements
- R1: While `rst` is high, and afterwards while `pwr_loss` stays high, the block stays in state off. In that state every rail enable, `lvcmos_oe`, `park_req` and `ctrl_rst_n` are low and `status` reads 0.
- R2: In state off with `pwr_loss` low, both logic rail enables rise on the next clock edge. No high-voltage enable rises before `vcc_good` and `vcci_good` have both been sampled high.
- R3: `lvcmos_oe` rises only after both logic supply flags have been sampled high, and never while a logic rail enable is low.
- R4: The offset and reset rail enables rise on the same edge. The bias enable rises exactly GAP_CYC cycles later, and bias is never on while offset is off.
- R5: In the running state, `sw_pdn_req` or `pwr_loss` makes `park_req` rise on the next edge. Every rail enable then stays unchanged for PARK_CYC cycles, where PARK_CYC is the ceiling of CLK_HZ × PARK_US / 10^6 (50 by default). Only after that does any high-voltage enable fall.
- R6: On shutdown the bias and reset enables fall on the same edge while offset stays on. The offset enable falls exactly GAP_CYC cycles later, with `park_req` still high.
- R7: The logic rail enables fall only while every high-voltage enable is low and `hv_discharged` was sampled high. After a shutdown caused by power loss, this ends in state off.
- R8: After a software shutdown, once `hv_discharged` is seen, the block keeps the logic rails on and holds `ctrl_rst_n` low for at least RST_CYC + 1 cycles, where RST_CYC is CLK_HZ × RST_MS / 1000 (5000 by default). It leaves the reset state only when `sw_pdn_req` is low, then powers up again without cycling the logic rails.
- R9: `pwr_loss` during logic bring-up or high-voltage bring-up sends the block to the park state on the next edge, holding whichever enables are already on.
- R10: `pwr_loss` during the controller-reset state sends the block to state off on the next edge, dropping the logic rails.
- R11: `status` encodes the state as off 0, logic-up 1, high-voltage-up 2, running 3, parking 4, discharging 5, resetting 6. In states 0, 1, 2, 3 and 6 the outputs {en_vcc, en_vcci, en_offset, en_bias, en_reset_rail, lvcmos_oe, park_req, ctrl_rst_n} are 00000000, 11000000, 11101101, 11111101 and 11000100 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_good | input | 1 | Core logic supply settled |
| vcci_good | input | 1 | Interface logic supply settled |
| pwr_loss | input | 1 | Input power loss detected (level) |
| sw_pdn_req | input | 1 | Software power-down request (level) |
| hv_discharged | input | 1 | All high-voltage rails near ground |
| en_vcc | output | 1 | Core logic supply enable |
| en_vcci | output | 1 | Interface logic supply enable |
| en_offset | output | 1 | Offset rail enable |
| en_bias | output | 1 | Bias rail enable |
| en_reset_rail | output | 1 | Reset rail enable |
| lvcmos_oe | output | 1 | Enable for LVCMOS-driven outputs |
| park_req | output | 1 | Mirror park request to the display controller |
| ctrl_rst_n | output | 1 | Active-low display controller reset |
| status | output | 3 | Current state code |

## Verification
The bench targets the exact spacing between offset and bias in both directions. A design that got the gap off by one, or dropped offset together with bias, would let the bias–offset difference exceed its limit. It measures the park hold from the park request to the first high-voltage drop; a design with a short hold would remove rails before the mirrors are flat. It injects power loss during logic bring-up, high-voltage bring-up, parking and the controller-reset pulse. A wrong design would then enable high voltage without settled logic supplies, drop logic rails before discharge, or return to running. It also holds the software request through the reset pulse; a design that ignores the request level would release the controller early.

// File: rtl/mmd_seq_pkg.sv
package mmd_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF     = 3'd0,
    ST_LOGIC   = 3'd1,
    ST_HVUP    = 3'd2,
    ST_RUN     = 3'd3,
    ST_PARK    = 3'd4,
    ST_DISCH   = 3'd5,
    ST_RESTART = 3'd6
  } seq_state_e;

  typedef struct packed {
    logic vcc;
    logic vcci;
    logic offset;
    logic bias;
    logic hvreset;
    logic oe;
    logic park;
    logic crst_n;
  } rail_vec_t;

  // Ceiling conversion of a duration in microseconds to clock cycles, at least one.
  function automatic int unsigned cycles_for_us(longint unsigned clk_hz, longint unsigned us);
    longint unsigned v;
    v = (clk_hz * us + 64'd999_999) / 64'd1_000_000;
    if (v == 0) v = 1;
    return int'(v);
  endfunction

  function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/mmd_seq_timer.sv
module mmd_seq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
  end

  assign done = (cnt_q == '0);

  // Interval counts strictly downward between loads (hold timing, R5).
  assert_count_down_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));

endmodule

// File: rtl/mmd_rail_outreg.sv
module mmd_rail_outreg
  import mmd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_e state_d,
  input  logic       phase_d,
  output rail_vec_t  rails
);

  rail_vec_t cur_q, nxt;

  always_comb begin
    nxt = cur_q;
    unique case (state_d)
      ST_OFF: nxt = '0;
      ST_LOGIC: begin
        nxt      = '0;
        nxt.vcc  = 1'b1;
        nxt.vcci = 1'b1;
      end
      ST_HVUP: begin
        nxt         = '0;
        nxt.vcc     = 1'b1;
        nxt.vcci    = 1'b1;
        nxt.offset  = 1'b1;
        nxt.hvreset = 1'b1;
        nxt.oe      = 1'b1;
        nxt.crst_n  = 1'b1;
      end
      ST_RUN: begin
        nxt      = '1;
        nxt.park = 1'b0;
      end
      ST_PARK: begin
        nxt      = cur_q;
        nxt.park = 1'b1;
      end
      ST_DISCH: begin
        nxt         = cur_q;
        nxt.bias    = 1'b0;
        nxt.hvreset = 1'b0;
        nxt.park    = 1'b1;
        if (phase_d) nxt.offset = 1'b0;
      end
      ST_RESTART: begin
        nxt      = '0;
        nxt.vcc  = 1'b1;
        nxt.vcci = 1'b1;
        nxt.oe   = 1'b1;
      end
      default: nxt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cur_q <= '0;
    else     cur_q <= nxt;
  end

  assign rails = cur_q;

  assert_bias_needs_offset_R4: assert property (@(posedge clk) disable iff (rst)
    cur_q.bias |-> cur_q.offset);

  assert_hv_needs_logic_R2: assert property (@(posedge clk) disable iff (rst)
    (cur_q.offset || cur_q.bias || cur_q.hvreset) |-> (cur_q.vcc && cur_q.vcci));

  assert_oe_needs_logic_R3: assert property (@(posedge clk) disable iff (rst)
    cur_q.oe |-> (cur_q.vcc && cur_q.vcci));

endmodule

// File: rtl/mmd_rail_seq.sv
module mmd_rail_seq
  import mmd_seq_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 100_000,
  parameter int unsigned PARK_US = 500,
  parameter int unsigned RST_MS  = 50,
  parameter int unsigned GAP_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vcc_good,
  input  logic       vcci_good,
  input  logic       pwr_loss,
  input  logic       sw_pdn_req,
  input  logic       hv_discharged,
  output logic       en_vcc,
  output logic       en_vcci,
  output logic       en_offset,
  output logic       en_bias,
  output logic       en_reset_rail,
  output logic       lvcmos_oe,
  output logic       park_req,
  output logic       ctrl_rst_n,
  output logic [2:0] status
);

  localparam int unsigned PARK_CYC = cycles_for_us(64'(CLK_HZ), 64'(PARK_US));
  localparam int unsigned RST_CYC  = cycles_for_us(64'(CLK_HZ), 64'(RST_MS) * 64'd1000);
  localparam int unsigned GAP_EFF  = (GAP_CYC == 0) ? 1 : GAP_CYC;
  localparam int unsigned MAX_CYC  = max3(PARK_CYC, RST_CYC, GAP_EFF);
  localparam int unsigned TW       = $clog2(MAX_CYC + 1);
  localparam int unsigned AW       = $clog2(PARK_CYC + 1) + 1;

  seq_state_e      state_q, state_d;
  logic            phase_q, phase_d;
  logic            loss_q, loss_d;
  logic            t_load, t_done;
  logic [TW-1:0]   t_val;
  rail_vec_t       rails;

  mmd_seq_timer #(.W(TW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (t_load),
    .load_val (t_val),
    .done     (t_done)
  );

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    loss_d  = loss_q;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (state_q)
      ST_OFF: begin
        if (!pwr_loss) state_d = ST_LOGIC;
      end
      ST_LOGIC: begin
        if (pwr_loss) begin
          state_d = ST_PARK; loss_d = 1'b1;
          t_load = 1'b1; t_val = TW'(PARK_CYC - 1);
        end else if (vcc_good && vcci_good) begin
          state_d = ST_HVUP;
          t_load = 1'b1; t_val = TW'(GAP_EFF - 1);
        end
      end
      ST_HVUP: begin
        if (pwr_loss) begin
          state_d = ST_PARK; loss_d = 1'b1;
          t_load = 1'b1; t_val = TW'(PARK_CYC - 1);
        end else if (t_done) begin
          state_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (pwr_loss || sw_pdn_req) begin
          state_d = ST_PARK; loss_d = pwr_loss;
          t_load = 1'b1; t_val = TW'(PARK_CYC - 1);
        end
      end
      ST_PARK: begin
        loss_d = loss_q | pwr_loss;
        if (t_done) begin
          state_d = ST_DISCH; phase_d = 1'b0;
          t_load = 1'b1; t_val = TW'(GAP_EFF - 1);
        end
      end
      ST_DISCH: begin
        loss_d = loss_q | pwr_loss;
        if (!phase_q) begin
          if (t_done) phase_d = 1'b1;
        end else if (hv_discharged) begin
          phase_d = 1'b0;
          loss_d  = 1'b0;
          if (loss_q || pwr_loss) begin
            state_d = ST_OFF;
          end else begin
            state_d = ST_RESTART;
            t_load = 1'b1; t_val = TW'(RST_CYC - 1);
          end
        end
      end
      ST_RESTART: begin
        if (pwr_loss)                 state_d = ST_OFF;
        else if (t_done && !sw_pdn_req) state_d = ST_LOGIC;
      end
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_OFF;
      phase_q <= 1'b0;
      loss_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      loss_q  <= loss_d;
    end
  end

  mmd_rail_outreg u_out (
    .clk     (clk),
    .rst     (rst),
    .state_d (state_d),
    .phase_d (phase_d),
    .rails   (rails)
  );

  assign en_vcc        = rails.vcc;
  assign en_vcci       = rails.vcci;
  assign en_offset     = rails.offset;
  assign en_bias       = rails.bias;
  assign en_reset_rail = rails.hvreset;
  assign lvcmos_oe     = rails.oe;
  assign park_req      = rails.park;
  assign ctrl_rst_n    = rails.crst_n;
  assign status        = state_q;

  // Independent age of the park request, saturating, for the hold check.
  logic [AW-1:0] park_age;
  always_ff @(posedge clk) begin
    if (rst || !park_req)               park_age <= '0;
    else if (park_age != AW'(PARK_CYC)) park_age <= park_age + AW'(1);
  end

  assert_park_hold_R5: assert property (@(posedge clk) disable iff (rst)
    ($fell(en_bias) || $fell(en_reset_rail)) |-> (park_age >= AW'(PARK_CYC)));

  assert_offset_last_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(en_offset) |-> (park_req && !en_bias && !en_reset_rail));

  assert_logic_after_hv_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(en_vcc) |-> (!en_offset && !en_bias && !en_reset_rail));

  assert_discharge_seen_R7: assert property (@(posedge clk) disable iff (rst)
    ($fell(en_vcc) && $past(state_q) == ST_DISCH) |-> $past(hv_discharged));

  assert_restart_held_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RESTART && sw_pdn_req && !pwr_loss) |=> (state_q == ST_RESTART));

  assert_status_legal_R11: assert property (@(posedge clk) disable iff (rst)
    status != 3'd7);

endmodule

// File: tb/mmd_rail_seq_tb_top.sv
module mmd_rail_seq_tb_top;

  localparam int GAP  = 4;
  localparam int PARK = 50;
  localparam int RSTC = 5000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, vcc_good, vcci_good, pwr_loss, sw_pdn_req, hv_discharged;
  logic en_vcc, en_vcci, en_offset, en_bias, en_reset_rail, lvcmos_oe, park_req, ctrl_rst_n;
  logic [2:0] status;

  int checks = 0;
  int errors = 0;
  int pg_dly = 2;
  int dis_dly = 3;
  bit pg_hold = 1'b0;
  bit finished = 1'b0;

  mmd_rail_seq #(.CLK_HZ(100_000), .PARK_US(500), .RST_MS(50), .GAP_CYC(GAP)) dut_i (
    .clk(clk), .rst(rst), .vcc_good(vcc_good), .vcci_good(vcci_good),
    .pwr_loss(pwr_loss), .sw_pdn_req(sw_pdn_req), .hv_discharged(hv_discharged),
    .en_vcc(en_vcc), .en_vcci(en_vcci), .en_offset(en_offset), .en_bias(en_bias),
    .en_reset_rail(en_reset_rail), .lvcmos_oe(lvcmos_oe), .park_req(park_req),
    .ctrl_rst_n(ctrl_rst_n), .status(status)
  );

  function automatic logic [7:0] out_vec();
    return {en_vcc, en_vcci, en_offset, en_bias, en_reset_rail, lvcmos_oe, park_req, ctrl_rst_n};
  endfunction

  // Expected outputs per settled state code (R11).
  function automatic logic [7:0] exp_vec(logic [2:0] s);
    case (s)
      3'd0:    return 8'b0000_0000;
      3'd1:    return 8'b1100_0000;
      3'd2:    return 8'b1110_1101;
      3'd3:    return 8'b1111_1101;
      3'd6:    return 8'b1100_0100;
      default: return 8'b0000_0000;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wait_status(input logic [2:0] s, input int lim, input string req);
    bit hit;
    hit = 1'b0;
    for (int i = 0; i < lim && !hit; i++) begin
      if (status == s) hit = 1'b1;
      else @(negedge clk);
    end
    chk(hit, req, "reach state", int'(status), int'(s));
  endtask

  // Monitor and supply model share one process to keep ordering fixed.
  initial begin
    logic p_off, p_bias, p_rr, p_vcc, p_oe, p_park, p_crst;
    int gcnt, pcnt, dcnt, rcnt, pg_cnt, dis_cnt;
    bit rflag, dflag, drop;
    p_off = 0; p_bias = 0; p_rr = 0; p_vcc = 0; p_oe = 0; p_park = 0; p_crst = 0;
    gcnt = 0; pcnt = 0; dcnt = 0; rcnt = 0; pg_cnt = 0; dis_cnt = 0;
    rflag = 0; dflag = 0;
    vcc_good = 0; vcci_good = 0; hv_discharged = 1;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (status inside {3'd0, 3'd1, 3'd2, 3'd3, 3'd6})
          chk(out_vec() == exp_vec(status), "R11", "outputs for state", int'(out_vec()), int'(exp_vec(status)));
        else
          chk(status == 3'd4 || status == 3'd5, "R11", "legal state code", int'(status), 4);
        gcnt = (en_offset && !p_off) ? 0 : gcnt + 1;
        if (en_offset && !p_off) begin
          chk(vcc_good && vcci_good, "R2", "logic settled before offset", int'(vcc_good && vcci_good), 1);
          chk(en_reset_rail, "R4", "reset rail with offset", int'(en_reset_rail), 1);
        end
        if (en_bias && !p_bias) chk(gcnt == GAP, "R4", "offset-to-bias gap", gcnt, GAP);
        if (lvcmos_oe && !p_oe) chk(vcc_good && vcci_good, "R3", "oe after logic settled", int'(vcc_good && vcci_good), 1);
        pcnt = (park_req && !p_park) ? 0 : pcnt + 1;
        drop = (p_bias && !en_bias) || (p_rr && !en_reset_rail);
        if (drop) begin
          chk(pcnt == PARK, "R5", "park hold before drop", pcnt, PARK);
          chk(!en_bias && !en_reset_rail && en_offset, "R6", "bias and reset drop first", int'(out_vec()), 0);
          dcnt = 0; dflag = 1;
        end else dcnt++;
        if (p_off && !en_offset) begin
          chk(dflag && dcnt == GAP, "R6", "bias-to-offset gap", dcnt, GAP);
          chk(park_req, "R6", "park held at offset drop", int'(park_req), 1);
          dflag = 0;
        end
        if (p_vcc && !en_vcc)
          chk(hv_discharged && !en_offset && !en_bias && !en_reset_rail, "R7", "logic drop after discharge",
              int'(hv_discharged), 1);
        if (p_crst && !ctrl_rst_n && status == 3'd6) begin rflag = 1; rcnt = 0; end
        else rcnt++;
        if (status == 3'd0) rflag = 0;
        if (!p_crst && ctrl_rst_n && rflag) begin
          chk(rcnt >= RSTC + 1, "R8", "controller reset pulse length", rcnt, RSTC + 1);
          rflag = 0;
        end
      end
      p_off = en_offset; p_bias = en_bias; p_rr = en_reset_rail; p_vcc = en_vcc;
      p_oe = lvcmos_oe; p_park = park_req; p_crst = ctrl_rst_n;
      if (!en_vcc || pg_hold) begin pg_cnt = 0; vcc_good = 0; vcci_good = 0; end
      else if (pg_cnt >= pg_dly) begin vcc_good = 1; vcci_good = 1; end
      else pg_cnt++;
      if (en_offset || en_bias || en_reset_rail) begin dis_cnt = 0; hv_discharged = 0; end
      else if (dis_cnt >= dis_dly) hv_discharged = 1;
      else dis_cnt++;
    end
  end

  task automatic sw_cycle();
    sw_pdn_req = 1;
    @(negedge clk);
    chk(status == 3'd4 && park_req, "R5", "park on software request", int'(status), 4);
    sw_pdn_req = 0;
    wait_status(3'd6, PARK + GAP + 100, "R8");
    wait_status(3'd3, RSTC + 200, "R8");
  endtask

  task automatic loss_cycle();
    pwr_loss = 1;
    @(negedge clk);
    chk(status == 3'd4 && park_req, "R5", "park on power loss", int'(status), 4);
    wait_status(3'd0, PARK + GAP + 100, "R7");
    chk(!en_vcc && !en_vcci, "R7", "logic rails off after loss", int'(en_vcc), 0);
    pwr_loss = 0;
    wait_status(3'd3, 200, "R2");
  endtask

  initial begin
    int kind, k;
    void'($urandom(32'd1234));
    rst = 1; pwr_loss = 1; sw_pdn_req = 0;
    repeat (3) @(negedge clk);
    chk(status == 3'd0, "R1", "status in reset", int'(status), 0);
    chk(out_vec() == 8'd0, "R1", "outputs in reset", int'(out_vec()), 0);
    rst = 0;
    repeat (3) @(negedge clk);
    chk(status == 3'd0 && !en_vcc, "R1", "off while power absent", int'(status), 0);
    pwr_loss = 0;
    @(negedge clk);
    chk(status == 3'd1 && en_vcc && en_vcci && !en_offset, "R2", "logic rails first", int'(out_vec()), 8'hC0);
    wait_status(3'd3, 200, "R2");

    sw_cycle();
    loss_cycle();

    // R9: loss while logic supplies not yet settled
    pwr_loss = 1;
    wait_status(3'd0, 200, "R9");
    pg_hold = 1; pwr_loss = 0;
    @(negedge clk);
    chk(status == 3'd1, "R9", "logic-up entered", int'(status), 1);
    repeat (5) @(negedge clk);
    pwr_loss = 1;
    @(negedge clk);
    chk(status == 3'd4 && en_vcc && !en_offset && !lvcmos_oe, "R9", "park from logic-up", int'(out_vec()), 8'hC2);
    wait_status(3'd0, PARK + GAP + 100, "R9");
    pg_hold = 0; pwr_loss = 0;
    wait_status(3'd2, 200, "R9");
    pwr_loss = 1;
    @(negedge clk);
    chk(status == 3'd4 && en_offset && !en_bias, "R9", "park from high-voltage-up", int'(status), 4);
    wait_status(3'd0, PARK + GAP + 100, "R9");
    pwr_loss = 0;
    wait_status(3'd3, 200, "R2");

    // R10: loss during controller reset pulse
    sw_pdn_req = 1; @(negedge clk); sw_pdn_req = 0;
    wait_status(3'd6, PARK + GAP + 100, "R10");
    repeat (20) @(negedge clk);
    pwr_loss = 1;
    @(negedge clk);
    chk(status == 3'd0 && !en_vcc, "R10", "off from resetting", int'(status), 0);
    pwr_loss = 0;
    wait_status(3'd3, 200, "R10");

    // R8: request held through the pulse keeps the controller in reset
    sw_pdn_req = 1;
    wait_status(3'd6, PARK + GAP + 100, "R8");
    repeat (RSTC + 20) @(negedge clk);
    chk(status == 3'd6 && !ctrl_rst_n, "R8", "held while request stays", int'(status), 6);
    sw_pdn_req = 0;
    wait_status(3'd3, 200, "R8");

    for (int it = 0; it < 12; it++) begin
      pg_dly = $urandom_range(0, 6);
      dis_dly = $urandom_range(0, 20);
      repeat ($urandom_range(1, 30)) @(negedge clk);
      kind = $urandom_range(0, 2);
      if (kind == 0) sw_cycle();
      else if (kind == 1) loss_cycle();
      else begin
        sw_pdn_req = 1; @(negedge clk); sw_pdn_req = 0;
        k = $urandom_range(1, PARK - 2);
        repeat (k) @(negedge clk);
        pwr_loss = 1;
        wait_status(3'd0, PARK + GAP + 100, "R7");
        chk(!en_vcc, "R7", "loss during park ends off", int'(en_vcc), 0);
        pwr_loss = 0;
        wait_status(3'd3, 200, "R2");
      end
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190_000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule